// File: doc/BRIEF.md
# Six-Source Interrupt Enable Gate

This block collects interrupt requests from six sources: two external lines, three timers and a serial port. Each request is gated by its own enable bit and by one global enable bit. The result is a registered per-source pending vector and a single any-pending line, which feed a downstream priority and vector stage. The CPU reads and writes an 8-bit enable register.

The sixth source is the second-generation timer. Its request is the OR of two sticky flags: an overflow flag and an external-event flag. Hardware pulses set these flags. Only a software write clears them; taking the interrupt does not.

Requests are captured only on a machine-cycle sample strobe. A flag that is set in one machine cycle therefore becomes visible as pending at the following sample.

Top module: `irq_enable_gate`

## Requirements
- R1: After reset, `en_rdata` is 0x00, `t2_flags` is 0, `pending` is 0 and `any_pending` is 0.
- R2: A write with `en_we` high stores bits 0 to 5 and bit 7 of `en_wdata`. Bit 6 ignores writes and always reads back as 0.
- R3: While enable bit 7 (the global enable) is 0, every sample produces `pending` = 0, whatever bits 0 to 5 hold.
- R4: With bit 7 set, `pending[i]` is 1 after a sample only if request i and enable bit i are both 1. Index order is 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial, 5 = timer 2.
- R5: The timer-2 request (index 5) is the OR of `t2_flags[0]` (overflow) and `t2_flags[1]` (external event).
- R6: `t2_ovf_set` sets `t2_flags[0]` and `t2_ext_set` sets `t2_flags[1]`. Each flag stays set until a write with `t2_flag_we` high loads it from `t2_flag_wdata`.
- R7: `pending` and `any_pending` change only on a clock edge where `sample_stb` is high.
- R8: A timer-2 flag set on the same edge as a sample is not seen by that sample. It first shows in `pending` at the next sample.
- R9: `any_pending` equals the OR of all `pending` bits.
- R10: A set pulse wins over a software write on the same edge, so the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | Machine-cycle sample strobe |
| ext0_req | input | 1 | External request 0 |
| tmr0_req | input | 1 | Timer 0 overflow flag |
| ext1_req | input | 1 | External request 1 |
| tmr1_req | input | 1 | Timer 1 overflow flag |
| ser_req | input | 1 | Serial port request |
| t2_ovf_set | input | 1 | Pulse that sets the timer-2 overflow flag |
| t2_ext_set | input | 1 | Pulse that sets the timer-2 external flag |
| t2_flag_we | input | 1 | Software write strobe for the timer-2 flags |
| t2_flag_wdata | input | 2 | Value loaded into the timer-2 flags |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read data |
| t2_flags | output | 2 | Timer-2 flags, bit 0 overflow, bit 1 external |
| pending | output | 6 | Gated, sampled pending vector |
| any_pending | output | 1 | OR of the pending vector |

## Verification
The ports reveal a wrong internal state quickly.
- A corrupted enable bit shows as a missing or extra `pending` bit at the first sample after the write, and directly on `en_rdata` one cycle after the write.
- A timer-2 flag that clears itself or fails to set shows on `t2_flags` on the next edge, and on `pending[5]` at the following sample.
- A sampler that updates outside the strobe shows as `pending` moving between strobes, within one cycle of a request change.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    localparam int NUM_SRC = 6;
    localparam int REG_W   = 8;
    localparam int IDX_EX0 = 0;
    localparam int IDX_TM0 = 1;
    localparam int IDX_EX1 = 2;
    localparam int IDX_TM1 = 3;
    localparam int IDX_SER = 4;
    localparam int IDX_TM2 = 5;
    localparam int IDX_RSV = 6;
    localparam int IDX_GLB = 7;

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic               any;
    } samp_state_t;

    typedef struct packed {
        logic ext;
        logic ovf;
    } t2_state_t;
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg
    import irq_gate_pkg::*;
#(
    parameter int W       = REG_W,
    parameter int RSV_BIT = IDX_RSV,
    parameter int GLB_BIT = IDX_GLB
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q
);
    localparam logic [W-1:0] KEEP_MASK = ~(W'(1) << RSV_BIT);

    logic [W-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (we) begin
            en_d = wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_q[RSV_BIT] == 1'b0);
    assert_glb_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> en_q[GLB_BIT] == $past(wdata[GLB_BIT]));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en_q));
endmodule

// File: rtl/irq_t2_flags.sv
module irq_t2_flags
    import irq_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_set,
    input  logic       ext_set,
    input  logic       sw_we,
    input  logic [1:0] sw_wdata,
    output logic [1:0] flags,
    output logic       req
);
    t2_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sw_we) begin
            st_d.ovf = sw_wdata[0];
            st_d.ext = sw_wdata[1];
        end
        if (ovf_set) st_d.ovf = 1'b1;
        if (ext_set) st_d.ext = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = {st_q.ext, st_q.ovf};
    assign req   = st_q.ovf | st_q.ext;

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> flags[0]);
    assert_ext_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_set |=> flags[1]);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> (flags & $past(flags)) == $past(flags));
endmodule

// File: rtl/irq_sampler.sv
module irq_sampler
    import irq_gate_pkg::*;
#(
    parameter int N       = NUM_SRC,
    parameter int W       = REG_W,
    parameter int GLB_BIT = IDX_GLB
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [N-1:0] req,
    input  logic [W-1:0] en,
    output logic [N-1:0] pend,
    output logic         any
);
    samp_state_t st_d, st_q;
    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = req[i] & en[i] & en[GLB_BIT];
    end

    always_comb begin
        st_d = st_q;
        if (stb) begin
            st_d.pend = gated;
            st_d.any  = |gated;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign any  = st_q.any;

    assert_glb_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !en[GLB_BIT]) |=> pend == '0);
    assert_only_on_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(pend) && $stable(any)));
    assert_enabled_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (pend & ~$past(en[N-1:0])) == '0);
    assert_any_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any == (pend != '0));
endmodule

// File: rtl/irq_enable_gate.sv
module irq_enable_gate
    import irq_gate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_stb,
    input  logic                ext0_req,
    input  logic                tmr0_req,
    input  logic                ext1_req,
    input  logic                tmr1_req,
    input  logic                ser_req,
    input  logic                t2_ovf_set,
    input  logic                t2_ext_set,
    input  logic                t2_flag_we,
    input  logic [1:0]          t2_flag_wdata,
    input  logic                en_we,
    input  logic [REG_W-1:0]    en_wdata,
    output logic [REG_W-1:0]    en_rdata,
    output logic [1:0]          t2_flags,
    output logic [NUM_SRC-1:0]  pending,
    output logic                any_pending
);
    logic [REG_W-1:0]   en_q;
    logic               t2_req;
    logic [NUM_SRC-1:0] req_vec;

    irq_en_reg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (en_we),
        .wdata (en_wdata),
        .en_q  (en_q)
    );

    irq_t2_flags u_t2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_set  (t2_ovf_set),
        .ext_set  (t2_ext_set),
        .sw_we    (t2_flag_we),
        .sw_wdata (t2_flag_wdata),
        .flags    (t2_flags),
        .req      (t2_req)
    );

    always_comb begin
        req_vec          = '0;
        req_vec[IDX_EX0] = ext0_req;
        req_vec[IDX_TM0] = tmr0_req;
        req_vec[IDX_EX1] = ext1_req;
        req_vec[IDX_TM1] = tmr1_req;
        req_vec[IDX_SER] = ser_req;
        req_vec[IDX_TM2] = t2_req;
    end

    irq_sampler u_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (sample_stb),
        .req   (req_vec),
        .en    (en_q),
        .pend  (pending),
        .any   (any_pending)
    );

    assign en_rdata = en_q;

    assert_t2_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && en_q[IDX_GLB] && en_q[IDX_TM2] && (t2_flags != 2'b00))
        |=> pending[IDX_TM2]);
endmodule

// File: tb/irq_enable_gate_bench.sv
module irq_enable_gate_bench;
    typedef struct {
        logic [5:0] pend;
        string      tag;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    logic sample_stb = 0;
    logic ext0_req = 0, tmr0_req = 0, ext1_req = 0, tmr1_req = 0, ser_req = 0;
    logic t2_ovf_set = 0, t2_ext_set = 0, t2_flag_we = 0;
    logic [1:0] t2_flag_wdata = 0;
    logic en_we = 0;
    logic [7:0] en_wdata = 0;
    logic [7:0] en_rdata;
    logic [1:0] t2_flags;
    logic [5:0] pending;
    logic       any_pending;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    exp_t q[$];
    logic [7:0] m_en = 0;
    logic [1:0] m_t2 = 0;

    always #5 clk = ~clk;

    irq_enable_gate u_irq_enable_gate (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .ext0_req(ext0_req), .tmr0_req(tmr0_req), .ext1_req(ext1_req),
        .tmr1_req(tmr1_req), .ser_req(ser_req),
        .t2_ovf_set(t2_ovf_set), .t2_ext_set(t2_ext_set),
        .t2_flag_we(t2_flag_we), .t2_flag_wdata(t2_flag_wdata),
        .en_we(en_we), .en_wdata(en_wdata), .en_rdata(en_rdata),
        .t2_flags(t2_flags), .pending(pending), .any_pending(any_pending)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] model_pend();
        logic [5:0] raw;
        raw = {(m_t2 != 2'b00), ser_req, tmr1_req, ext1_req, tmr0_req, ext0_req};
        return raw & m_en[5:0] & {6{m_en[7]}};
    endfunction

    // monitor: pops expected items and compares with outputs
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                check({it.tag, " pending"}, 32'(pending), 32'(it.pend));
                check({it.tag, " any_pending R9"}, 32'(any_pending), 32'(it.pend != 0));
            end
        end
    end

    task automatic write_en(input logic [7:0] v);
        @(negedge clk);
        en_we = 1; en_wdata = v;
        @(posedge clk); #1;
        en_we = 0;
        m_en = v & 8'hBF;
    endtask

    // one cycle of stimulus; with stb the expected sample is queued
    task automatic cyc(input bit stb, input bit ovf, input bit ext,
                       input bit fwe, input logic [1:0] fwd, input string tag);
        logic [5:0] e;
        @(negedge clk);
        sample_stb = stb; t2_ovf_set = ovf; t2_ext_set = ext;
        t2_flag_we = fwe; t2_flag_wdata = fwd;
        e = model_pend();
        @(posedge clk); #1;
        sample_stb = 0; t2_ovf_set = 0; t2_ext_set = 0; t2_flag_we = 0;
        if (fwe) m_t2 = fwd;
        m_t2 = m_t2 | {ext, ovf};
        if (stb) begin
            exp_t it;
            it.pend = e; it.tag = tag;
            q.push_back(it);
        end
    endtask

    task automatic set_raw(input logic [4:0] v);
        @(negedge clk);
        {ser_req, tmr1_req, ext1_req, tmr0_req, ext0_req} = v;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [5:0] held;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1 en_rdata", 32'(en_rdata), 0);
        check("R1 t2_flags", 32'(t2_flags), 0);
        check("R1 pending", 32'(pending), 0);
        check("R1 any_pending", 32'(any_pending), 0);

        write_en(8'hFF);
        @(negedge clk);
        check("R2 reserved bit reads 0", 32'(en_rdata), 32'hBF);
        write_en(8'h40);
        @(negedge clk);
        check("R2 write only reserved", 32'(en_rdata), 0);

        write_en(8'h3F);
        set_raw(5'h1F);
        cyc(1, 0, 0, 0, 2'b00, "R3 global off");

        write_en(8'h85);
        cyc(1, 0, 0, 0, 2'b00, "R4 ext0+ext1");
        write_en(8'h8A);
        cyc(1, 0, 0, 0, 2'b00, "R4 tmr0+tmr1");
        write_en(8'h90);
        set_raw(5'h10);
        cyc(1, 0, 0, 0, 2'b00, "R4 serial only");
        write_en(8'h80);
        set_raw(5'h1F);
        cyc(1, 0, 0, 0, 2'b00, "R4 no individual enable");

        write_en(8'h9F);
        cyc(1, 0, 0, 0, 2'b00, "R4 all five");
        @(negedge clk);
        held = pending;
        set_raw(5'h00);
        cyc(0, 0, 0, 0, 2'b00, "");
        cyc(0, 0, 0, 0, 2'b00, "");
        @(negedge clk);
        check("R7 stable between strobes", 32'(pending), 32'(held));
        cyc(1, 0, 0, 0, 2'b00, "R7 next strobe updates");

        write_en(8'hA0);
        cyc(1, 1, 0, 0, 2'b00, "R8 same-edge set not seen");
        cyc(1, 0, 0, 0, 2'b00, "R5 overflow flag request");
        @(negedge clk);
        check("R6 overflow flag set", 32'(t2_flags), 32'h1);
        cyc(0, 0, 0, 1, 2'b00, "");
        @(negedge clk);
        check("R6 software clear", 32'(t2_flags), 0);
        cyc(1, 0, 0, 0, 2'b00, "R5 no flag no request");
        cyc(0, 0, 1, 0, 2'b00, "");
        repeat (10) cyc(0, 0, 0, 0, 2'b00, "");
        @(negedge clk);
        check("R6 external flag held", 32'(t2_flags), 32'h2);
        cyc(1, 0, 0, 0, 2'b00, "R5 external flag request");
        cyc(0, 1, 0, 1, 2'b00, "");
        @(negedge clk);
        check("R10 set beats clear", 32'(t2_flags), 32'h1);
        write_en(8'h20);
        cyc(1, 0, 0, 0, 2'b00, "R3 timer2 with global off");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule